// File: doc/BRIEF.md
# Pseudo-static RAM power-state and mode-register controller

This block tracks the power state of a low-power pseudo-static RAM from its control pins. After reset it waits for chip select to stay deasserted for a programmable power-up time, then follows the pins between an initial state, an active state and a standby state. When the sleep pin is pulled low, the device enters a sleep state that keeps the array contents. A mode-register write made through the address bus during sleep is held pending and lands only when the sleep pin returns high.

The mode register carries two fields: page-mode enable and a deep power-down arm. When deep power-down is armed, a long enough sleep with no early register write drops the device into deep power-down, and the array contents are lost. Waking from deep power-down restores the register defaults and starts a recovery interval during which no access is allowed.

All microsecond intervals are counted in clock cycles through a cycles-per-microsecond parameter. Pins are sampled on the rising clock edge. The controller reports its state code, whether array contents are retained, whether an access may start, the two register fields, and a one-cycle flag for a rejected register write.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: While reset is asserted, `state` is 0 (power-up wait), `access_ok`, `data_valid`, `page_mode`, `deep_armed` and `mode_err` are 0. State codes: 0 power-up wait, 1 initial, 2 standby, 3 active, 4 sleep, 5 deep power-down, 6 recovery.
- R2: The power-up wait moves to initial on the PWRUP_US*CYC_PER_US-th consecutive rising edge that samples `cs_n` high. An edge that samples `cs_n` low restarts the count.
- R3: From initial or standby, an edge that samples `zz_n` high, `cs_n` low and at least one of `ub_n`/`lb_n` low moves to active.
- R4: From active, an edge that samples `zz_n` high together with `cs_n` high or both byte enables high moves to standby.
- R5: From initial, standby or active, an edge that samples `zz_n` low moves to sleep. Contents stay retained and access is not allowed.
- R6: A register write starts on the first edge in sleep context that samples `cs_n`, `we_n` and one byte enable low. It is accepted only if `addr[6:5]`=11, `addr[3:0]`=0 and every address bit above bit 7 is 0. In an accepted write, `addr[7]` is the page-mode enable and `addr[4]`=0 arms deep power-down.
- R7: An accepted value leaves `page_mode`/`deep_armed` unchanged until the edge that samples `zz_n` high in sleep. On that edge it is applied and the state becomes standby.
- R8: A write with any other address leaves the register unchanged and raises `mode_err` for exactly one cycle, one edge after the write starts.
- R9: In sleep, if deep power-down is armed and no accepted write started during the first WIN_US*CYC_PER_US edges of sleep, the ZZMIN_US*CYC_PER_US-th edge in sleep moves to deep power-down (`data_valid`=0).
- R10: If deep power-down is not armed, or an accepted write started inside that window, the device stays in sleep for as long as `zz_n` is low, with contents retained.
- R11: An edge that samples `zz_n` high in deep power-down moves to recovery and restores the defaults (page mode off, deep power-down not armed), dropping any pending value. The RECOV_US*CYC_PER_US-th edge in recovery moves to initial.
- R12: `access_ok` is 1 exactly in initial, standby and active. `data_valid` is 0 exactly in power-up wait, deep power-down and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| we_n | input | 1 | Write enable, active low |
| zz_n | input | 1 | Sleep pin, low requests sleep |
| addr | input | ADDR_W | Address bus, carries register writes |
| state | output | 3 | Current power state code |
| data_valid | output | 1 | Array contents retained |
| access_ok | output | 1 | An access may start |
| page_mode | output | 1 | Page mode enabled in the register |
| deep_armed | output | 1 | Deep power-down armed in the register |
| mode_err | output | 1 | One-cycle pulse on a rejected register write |

## Verification
The assertions assume that every pin is already synchronous to `clk` and stable around the rising edge. They also assume that a register write is released before the sleep pin rises, so the standby entry on wake is not followed at once by an access. The bench changes every input only on falling edges and always deasserts chip select and write enable before raising `zz_n`. It sweeps all 256 low-address patterns through a full sleep/write/wake cycle, comparing the register fields with an arithmetic model of the decode rule. Timing windows are exercised at their exact edge counts, with a small cycles-per-microsecond value.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP  = 3'd0,
      ST_INIT   = 3'd1,
      ST_STBY   = 3'd2,
      ST_ACTIVE = 3'd3,
      ST_SLEEP  = 3'd4,
      ST_DEEP   = 3'd5,
      ST_RECOV  = 3'd6
   } pstate_t;

   localparam int unsigned MR_PAGE_BIT = 7;
   localparam int unsigned MR_DEEP_BIT = 4;

   // fixed-pattern part of the low address byte of a register write
   function automatic logic mr_low_ok(input logic [7:0] a);
      return (a[6:5] == 2'b11) && (a[3:0] == 4'd0);
   endfunction

endpackage

// File: rtl/psram_cyc_timer.sv
module psram_cyc_timer #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [WIDTH-1:0] cnt
);
   if (WIDTH < 2) begin : g_bad_width
      $error("psram_cyc_timer: WIDTH must be at least 2");
   end

   // saturating cycle counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != '1)  cnt <= cnt + 1'b1;
   end

   AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));  // R2
endmodule

// File: rtl/psram_mode_reg.sv
module psram_mode_reg
   import psram_pwr_pkg::*;
#(
   parameter int unsigned ADDR_W = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              apply,
   input  logic              restore,
   output logic              page_en,
   output logic              deep_armed,
   output logic              mode_err,
   output logic              wr_accept
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("psram_mode_reg: ADDR_W must be at least 8");
   end

   logic hi_ok, addr_ok, wr_cond, wr_q, wr_start, wr_reject;
   logic pend_v, pend_page, pend_dis, deep_dis;

   // upper address bits must be zero when the bus is wider than a byte
   if (ADDR_W > 8) begin : g_hi
      assign hi_ok = ~|addr[ADDR_W-1:8];
   end else begin : g_nohi
      assign hi_ok = 1'b1;
   end

   assign addr_ok   = hi_ok && mr_low_ok(addr[7:0]);
   assign wr_cond   = cap_en && !cs_n && !we_n && (!ub_n || !lb_n);
   assign wr_start  = wr_cond && !wr_q;
   assign wr_accept = wr_start && addr_ok;
   assign wr_reject = wr_start && !addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         mode_err <= 1'b0;
      end else begin
         wr_q     <= wr_cond;
         mode_err <= wr_reject;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_page <= 1'b0;
         pend_dis  <= 1'b1;
      end else if (apply || restore) begin
         pend_v    <= 1'b0;
      end else if (wr_accept) begin
         pend_v    <= 1'b1;
         pend_page <= addr[MR_PAGE_BIT];
         pend_dis  <= addr[MR_DEEP_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_en  <= 1'b0;
         deep_dis <= 1'b1;
      end else if (restore) begin
         page_en  <= 1'b0;
         deep_dis <= 1'b1;
      end else if (apply && pend_v) begin
         page_en  <= pend_page;
         deep_dis <= pend_dis;
      end
   end

   assign deep_armed = !deep_dis;

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> !mode_err);  // R8
   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply && !restore) |=> ($stable(page_en) && $stable(deep_dis)));  // R7
   AST_RESTORE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (!page_en && deep_dis));  // R11
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
   import psram_pwr_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 200,
   parameter int unsigned PWRUP_US   = 200,
   parameter int unsigned RECOV_US   = 200,
   parameter int unsigned ZZMIN_US   = 10,
   parameter int unsigned WIN_US     = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cs_n,
   input  logic    ub_n,
   input  logic    lb_n,
   input  logic    zz_n,
   input  logic    deep_armed,
   input  logic    wr_accept,
   output pstate_t state,
   output logic    cap_en,
   output logic    apply,
   output logic    restore,
   output logic    access_ok,
   output logic    data_valid
);
   localparam int unsigned PW_CYC  = PWRUP_US * CYC_PER_US;
   localparam int unsigned RC_CYC  = RECOV_US * CYC_PER_US;
   localparam int unsigned ZZ_CYC  = ZZMIN_US * CYC_PER_US;
   localparam int unsigned WIN_CYC = WIN_US * CYC_PER_US;
   localparam int unsigned TMAX_A  = (PW_CYC > RC_CYC) ? PW_CYC : RC_CYC;
   localparam int unsigned TMAX    = (TMAX_A > ZZ_CYC) ? TMAX_A : ZZ_CYC;
   localparam int unsigned TW      = $clog2(TMAX + 2);

   if (CYC_PER_US < 1 || PWRUP_US < 1 || RECOV_US < 1 || WIN_US < 1) begin : g_bad_time
      $error("psram_pwr_fsm: all time parameters must be at least 1");
   end
   if (WIN_US >= ZZMIN_US) begin : g_bad_win
      $error("psram_pwr_fsm: WIN_US must be shorter than ZZMIN_US");
   end

   logic [TW-1:0] tmr;
   logic          tmr_clr, be_any, zz_lo, inh;
   pstate_t       nxt;

   psram_cyc_timer #(.WIDTH(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
   );

   assign be_any = !ub_n || !lb_n;
   assign zz_lo  = !zz_n;

   always_comb begin
      nxt     = state;
      apply   = 1'b0;
      restore = 1'b0;
      case (state)
         ST_PWRUP:  if (cs_n && tmr == TW'(PW_CYC - 1)) nxt = ST_INIT;
         ST_INIT, ST_STBY: begin
            if (zz_lo)                  nxt = ST_SLEEP;
            else if (!cs_n && be_any)   nxt = ST_ACTIVE;
         end
         ST_ACTIVE: begin
            if (zz_lo)                  nxt = ST_SLEEP;
            else if (cs_n || !be_any)   nxt = ST_STBY;
         end
         ST_SLEEP: begin
            if (!zz_lo) begin
               nxt   = ST_STBY;
               apply = 1'b1;
            end else if (tmr == TW'(ZZ_CYC - 1) && deep_armed && !inh) begin
               nxt   = ST_DEEP;
            end
         end
         ST_DEEP: begin
            if (!zz_lo) begin
               nxt     = ST_RECOV;
               restore = 1'b1;
            end
         end
         ST_RECOV:  if (tmr == TW'(RC_CYC - 1)) nxt = ST_INIT;
         default:   nxt = ST_PWRUP;
      endcase
   end

   assign tmr_clr = (nxt != state) || (state == ST_PWRUP && !cs_n);
   assign cap_en  = zz_lo && (state == ST_INIT || state == ST_STBY ||
                              state == ST_ACTIVE || state == ST_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_PWRUP;
         inh   <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_SLEEP) inh <= inh || (wr_accept && tmr < TW'(WIN_CYC));
         else                   inh <= wr_accept;
      end
   end

   assign access_ok  = (state == ST_INIT) || (state == ST_STBY) || (state == ST_ACTIVE);
   assign data_valid = !((state == ST_PWRUP) || (state == ST_DEEP) || (state == ST_RECOV));

   AST_ACT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_INIT || state == ST_STBY) && zz_n && !cs_n && be_any)
      |=> (state == ST_ACTIVE));  // R3
   AST_ACT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && zz_n && (cs_n || (ub_n && lb_n))) |=> (state == ST_STBY));  // R4
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_INIT || state == ST_STBY || state == ST_ACTIVE) && !zz_n)
      |=> (state == ST_SLEEP));  // R5
   AST_DEEP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEEP && $past(state) != ST_DEEP)
      |-> ($past(state) == ST_SLEEP && $past(deep_armed)));  // R9
   AST_RECOV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RECOV && $past(state) != ST_RECOV) |-> ($past(state) == ST_DEEP));  // R11
   AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEEP && zz_n) |=> (state == ST_RECOV && !deep_armed));  // R11
endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
   import psram_pwr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 22,
   parameter int unsigned CYC_PER_US = 200,
   parameter int unsigned PWRUP_US   = 200,
   parameter int unsigned RECOV_US   = 200,
   parameter int unsigned ZZMIN_US   = 10,
   parameter int unsigned WIN_US     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ub_n,
   input  logic              lb_n,
   input  logic              we_n,
   input  logic              zz_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [2:0]        state,
   output logic              data_valid,
   output logic              access_ok,
   output logic              page_mode,
   output logic              deep_armed,
   output logic              mode_err
);
   pstate_t st;
   logic    cap_en, apply, restore, wr_accept;

   psram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
      .cs_n(cs_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
      .apply(apply), .restore(restore),
      .page_en(page_mode), .deep_armed(deep_armed),
      .mode_err(mode_err), .wr_accept(wr_accept)
   );

   psram_pwr_fsm #(
      .CYC_PER_US(CYC_PER_US), .PWRUP_US(PWRUP_US), .RECOV_US(RECOV_US),
      .ZZMIN_US(ZZMIN_US), .WIN_US(WIN_US)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ub_n(ub_n), .lb_n(lb_n),
      .zz_n(zz_n), .deep_armed(deep_armed), .wr_accept(wr_accept),
      .state(st), .cap_en(cap_en), .apply(apply), .restore(restore),
      .access_ok(access_ok), .data_valid(data_valid)
   );

   assign state = st;

   AST_ERR_NOT_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (st == ST_SLEEP || $past(st) != ST_SLEEP || $past(zz_n) == 1'b0));  // R8
endmodule

// File: tb/psram_pwr_ctrl_test.sv
`timescale 1ns/1ps
module psram_pwr_ctrl_test;
   localparam int AW  = 10;
   localparam int CPU = 4;
   localparam int PW  = 200 * CPU;
   localparam int RC  = 200 * CPU;
   localparam int ZZ  = 10 * CPU;
   localparam int WN  = 1 * CPU;

   localparam int S_PWRUP = 0, S_INIT = 1, S_STBY = 2, S_ACT = 3,
                  S_SLEEP = 4, S_DEEP = 5, S_RECOV = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1, we_n = 1'b1, zz_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [2:0] state;
   logic data_valid, access_ok, page_mode, deep_armed, mode_err;

   int checks = 0, fails = 0;
   int exp_page = 0, exp_arm = 0;

   always #2.5 clk = ~clk;

   psram_pwr_ctrl #(.ADDR_W(AW), .CYC_PER_US(CPU), .PWRUP_US(200), .RECOV_US(200),
                    .ZZMIN_US(10), .WIN_US(1)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ub_n(ub_n), .lb_n(lb_n), .we_n(we_n),
      .zz_n(zz_n), .addr(addr), .state(state), .data_valid(data_valid),
      .access_ok(access_ok), .page_mode(page_mode), .deep_armed(deep_armed),
      .mode_err(mode_err)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input int exp_st);
      chk({req, " state"}, int'(state), exp_st);
      chk({req, " access_ok"}, int'(access_ok),
          (exp_st == S_INIT || exp_st == S_STBY || exp_st == S_ACT) ? 1 : 0);
      chk({req, " data_valid"}, int'(data_valid),
          (exp_st == S_PWRUP || exp_st == S_DEEP || exp_st == S_RECOV) ? 0 : 1);
   endtask

   function automatic int addr_good(input int a);
      return (((a >> 5) & 3) == 3 && (a & 15) == 0 && (a >> 8) == 0) ? 1 : 0;
   endfunction

   // full sleep / write / wake cycle with one register write
   task automatic mode_cycle(input int a);
      int good;
      good = addr_good(a);
      zz_n = 1'b0;
      step(1);
      cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; addr = AW'(a);
      step(1);
      chk("R8 mode_err pulse", int'(mode_err), good ? 0 : 1);
      cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1;
      step(1);
      chk("R8 mode_err one cycle", int'(mode_err), 0);
      chk("R7 page held in sleep", int'(page_mode), exp_page);
      chk("R7 arm held in sleep", int'(deep_armed), exp_arm);
      if (good != 0) begin
         exp_page = (a >> 7) & 1;
         exp_arm  = ((a >> 4) & 1) ? 0 : 1;
      end
      zz_n = 1'b1;
      step(1);
      chk("R6 page field", int'(page_mode), exp_page);
      chk("R6 arm field", int'(deep_armed), exp_arm);
      chk("R7 wake to standby", int'(state), S_STBY);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      step(3);
      chk_state("R1 reset", S_PWRUP);
      chk("R1 page", int'(page_mode), 0);
      chk("R1 arm", int'(deep_armed), 0);
      chk("R1 err", int'(mode_err), 0);
      rst_n = 1'b1;

      // R2: power-up count, restarted by a chip-select glitch
      step(100);
      cs_n = 1'b0;
      step(1);
      cs_n = 1'b1;
      step(PW - 1);
      chk_state("R2 still waiting", S_PWRUP);
      step(1);
      chk_state("R2 initial reached", S_INIT);

      // R3 / R4 active and standby moves
      cs_n = 1'b0; ub_n = 1'b0;
      step(1);
      chk_state("R3 init to active", S_ACT);
      ub_n = 1'b1;
      step(1);
      chk_state("R4 both enables high", S_STBY);
      lb_n = 1'b0;
      step(1);
      chk_state("R3 standby to active", S_ACT);
      cs_n = 1'b1;
      step(1);
      chk_state("R4 chip select high", S_STBY);
      cs_n = 1'b0;
      step(1);
      chk_state("R3 lower byte active", S_ACT);
      cs_n = 1'b1; lb_n = 1'b1; zz_n = 1'b0;
      step(1);
      chk_state("R5 active to sleep", S_SLEEP);
      zz_n = 1'b1;
      step(1);
      chk_state("R12 wake standby", S_STBY);

      // R6 R7 R8: sweep of every low address byte, plus an upper-bit case
      for (int a = 0; a < 256; a++) mode_cycle(a);
      mode_cycle(9'h160);
      chk("R6 upper bit rejected page", int'(page_mode), exp_page);

      // R10: not armed, long sleep keeps data
      mode_cycle(8'h70);
      zz_n = 1'b0;
      step(ZZ + 5);
      chk_state("R10 unarmed long sleep", S_SLEEP);
      zz_n = 1'b1;
      step(1);
      chk_state("R10 wake", S_STBY);

      // arm deep power-down, then an early write inhibits entry
      mode_cycle(8'h60);
      chk("R9 armed", int'(deep_armed), 1);
      zz_n = 1'b0;
      step(WN);
      cs_n = 1'b0; we_n = 1'b0; ub_n = 1'b0; addr = AW'(8'h60);
      step(1);
      cs_n = 1'b1; we_n = 1'b1; ub_n = 1'b1;
      step(ZZ + 3 - WN - 1);
      chk_state("R10 inhibited by early write", S_SLEEP);
      zz_n = 1'b1;
      step(1);
      chk_state("R10 wake after inhibit", S_STBY);

      // late write does not inhibit: entry at the exact edge
      zz_n = 1'b0;
      step(WN + 1);
      cs_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; addr = AW'(8'hE0);
      step(1);
      cs_n = 1'b1; we_n = 1'b1; lb_n = 1'b1;
      step(ZZ - (WN + 2));
      chk_state("R9 one edge before entry", S_SLEEP);
      step(1);
      chk_state("R9 deep entered", S_DEEP);
      chk("R7 pending not applied", int'(page_mode), 0);

      // R11 wake from deep power-down
      zz_n = 1'b1;
      step(1);
      chk_state("R11 recovery", S_RECOV);
      chk("R11 page default", int'(page_mode), 0);
      chk("R11 arm default", int'(deep_armed), 0);
      exp_page = 0; exp_arm = 0;
      step(RC - 1);
      chk_state("R11 still recovering", S_RECOV);
      step(1);
      chk_state("R11 initial after recovery", S_INIT);

      // deep entry with no write at all
      mode_cycle(8'h60);
      zz_n = 1'b0;
      step(ZZ);
      chk_state("R9 no write before entry", S_SLEEP);
      step(1);
      chk_state("R9 no write deep", S_DEEP);
      zz_n = 1'b1;
      step(RC + 1);
      chk_state("R11 second recovery done", S_INIT);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule